// File: doc/BRIEF.md
# Giant Frame Length Checker

This block watches the receive byte stream of an Ethernet MAC and reports, once per frame, whether the frame was longer than the allowed maximum. It does not take part in the handshake. It samples the valid and ready signals of the stream alongside the data, start and end markers, and counts only bytes that actually transfer. Back-pressure from the consumer therefore never inflates the count. A cycle with valid high and ready low carries no byte, and its data, start and end markers are ignored.

The allowed maximum comes from a programmable limit field. That field is used only when its enable is set, and any programmed value below 1518 is raised to 1518. When the enable is clear, the maximum is fixed at 1518. In both cases the checker finds VLAN tags itself by comparing the header bytes against the customer and service tag identifiers. It adds 4 bytes to the maximum for one tag and 8 bytes for two tags.

The verdict appears on the cycle after the end-of-frame byte transfers, as a single-cycle result strobe with a flag beside it. The byte counter saturates, so frames of any length are still flagged.

Top module: `giant_frame_checker`

## Requirements
- R1: After reset, `res_valid` and `res_giant` are both low.
- R2: A byte is counted only in a cycle where `s_valid` and `s_ready` are both high. In a cycle with `s_ready` low, the data, `s_sof` and `s_eof` have no effect on the count, on tag detection or on the outputs.
- R3: `res_valid` is high for exactly the one cycle after a transfer that carries `s_eof`, and at no other time. `res_giant` is never high without `res_valid`.
- R4: With frame size N (the number of bytes transferred from the `s_sof` byte through the `s_eof` byte) and effective limit L, `res_giant` is high when N > L. It is low when N == L or N < L.
- R5: When `cfg_limit_en` is 1, L starts from `cfg_limit`. Any `cfg_limit` value below 1518 is treated as exactly 1518.
- R6: When `cfg_limit_en` is 0, L starts from 1518 whatever `cfg_limit` holds.
- R7: Byte positions count from 0 at the `s_sof` byte. If bytes 12 and 13, read as one big-endian 16-bit value, equal 0x8100 or 0x88A8, the frame has one tag and L grows by 4.
- R8: If the frame has an outer tag and bytes 16 and 17, read as one big-endian value, equal 0x8100, the frame has two tags and L grows by 8 in total.
- R9: The byte count saturates at 65535 and does not wrap, so a frame of more than 65535 bytes is flagged giant.
- R10: A transfer with `s_sof` high starts a new count at 1 and clears the tag state, even if the previous frame never ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream valid, as seen on the receive path |
| s_ready | input | 1 | Stream ready, as seen on the receive path |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_eof | input | 1 | Marks the last byte of a frame |
| cfg_limit | input | 14 | Programmed size limit in bytes |
| cfg_limit_en | input | 1 | Selects the programmed limit instead of the fixed 1518 |
| res_valid | output | 1 | One-cycle strobe after the last byte transfers |
| res_giant | output | 1 | Frame exceeded the effective limit; meaningful with res_valid |

## Verification
Untagged, single-tagged (with both tag identifiers) and double-tagged frames are sent at exactly the effective limit and one byte above it. This pins down the strict comparison and each tag adjustment separately. Programmed limits above, below and with the enable clear show apart the programmed path, the 1518 floor and the fixed default. Frames with stall cycles carrying false start and end markers show that only handshaked bytes count. A frame abandoned without an end marker shows that a new start restarts the count. A frame longer than the counter range tells saturation apart from wrap-around.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  typedef enum logic [1:0] {
    TAGS_NONE = 2'd0,
    TAGS_ONE  = 2'd1,
    TAGS_TWO  = 2'd2
  } tag_cnt_e;

  localparam logic [15:0] TPID_CUST = 16'h8100;
  localparam logic [15:0] TPID_SERV = 16'h88A8;
  localparam int          OUTER_TAG_POS = 12;
  localparam int          INNER_TAG_POS = 16;
endpackage

// File: rtl/gfc_byte_counter.sv
module gfc_byte_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [LEN_W-1:0] pos,
  output logic [LEN_W-1:0] size
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;

  always_comb begin
    pos = sof ? '0 : cnt_q;
    if (sof)
      size = LEN_W'(1);
    else if (cnt_q == CNT_MAX)
      size = CNT_MAX;
    else
      size = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (beat)
      cnt_q <= size;
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(cnt_q));

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> cnt_q == LEN_W'(1));
endmodule

// File: rtl/gfc_tag_detect.sv
module gfc_tag_detect
  import gfc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] pos,
  output tag_cnt_e         tags
);
  logic [7:0] prev_q;
  logic       outer_q;
  logic       inner_q;
  logic [15:0] pair;

  assign pair = {prev_q, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      outer_q <= 1'b0;
      inner_q <= 1'b0;
    end else if (beat) begin
      prev_q <= data;
      if (sof) begin
        outer_q <= 1'b0;
        inner_q <= 1'b0;
      end else if (pos == LEN_W'(OUTER_TAG_POS + 1)) begin
        outer_q <= (pair == TPID_CUST) || (pair == TPID_SERV);
      end else if (pos == LEN_W'(INNER_TAG_POS + 1)) begin
        inner_q <= outer_q && (pair == TPID_CUST);
      end
    end
  end

  always_comb begin
    if (inner_q)      tags = TAGS_TWO;
    else if (outer_q) tags = TAGS_ONE;
    else              tags = TAGS_NONE;
  end

  p_inner_needs_outer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inner_q |-> outer_q);

  p_sof_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (!outer_q && !inner_q));
endmodule

// File: rtl/gfc_limit_calc.sv
module gfc_limit_calc
  import gfc_pkg::*;
#(
  parameter int LIM_W     = 14,
  parameter int LEN_W     = 16,
  parameter int MIN_LIMIT = 1518,
  parameter int TAG_BYTES = 4
) (
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_limit_en,
  input  tag_cnt_e         tags,
  output logic [LEN_W-1:0] eff_limit
);
  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_LIMIT);

  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] adj;

  always_comb begin
    if (cfg_limit_en && (LEN_W'(cfg_limit) >= FLOOR))
      base = LEN_W'(cfg_limit);
    else
      base = FLOOR;
    adj       = LEN_W'(TAG_BYTES) * LEN_W'(tags);
    eff_limit = base + adj;
  end
endmodule

// File: rtl/giant_frame_checker.sv
module giant_frame_checker
  import gfc_pkg::*;
#(
  parameter int LIM_W     = 14,
  parameter int LEN_W     = 16,
  parameter int MIN_LIMIT = 1518,
  parameter int TAG_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_sof,
  input  logic             s_eof,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_limit_en,
  output logic             res_valid,
  output logic             res_giant
);
  logic             beat;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] size;
  logic [LEN_W-1:0] eff_limit;
  tag_cnt_e         tags;

  assign beat = s_valid && s_ready;

  gfc_byte_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .beat (beat),
    .sof  (s_sof),
    .pos  (pos),
    .size (size)
  );

  gfc_tag_detect #(.LEN_W(LEN_W)) u_tag (
    .clk  (clk),
    .rst_n(rst_n),
    .beat (beat),
    .sof  (s_sof),
    .data (s_data),
    .pos  (pos),
    .tags (tags)
  );

  gfc_limit_calc #(
    .LIM_W    (LIM_W),
    .LEN_W    (LEN_W),
    .MIN_LIMIT(MIN_LIMIT),
    .TAG_BYTES(TAG_BYTES)
  ) u_lim (
    .cfg_limit   (cfg_limit),
    .cfg_limit_en(cfg_limit_en),
    .tags        (tags),
    .eff_limit   (eff_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_giant <= 1'b0;
    end else begin
      res_valid <= beat && s_eof;
      res_giant <= beat && s_eof && (size > eff_limit);
    end
  end

  p_flag_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_giant |-> res_valid);

  p_valid_after_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(s_valid && s_ready && s_eof));

  p_limit_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eff_limit >= LEN_W'(MIN_LIMIT));
endmodule

// File: tb/giant_frame_checker_test.sv
module giant_frame_checker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid, s_ready, s_sof, s_eof;
  logic [7:0]  s_data;
  logic [13:0] cfg_limit;
  logic        cfg_limit_en;
  logic        res_valid, res_giant;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  giant_frame_checker uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .cfg_limit(cfg_limit),
    .cfg_limit_en(cfg_limit_en), .res_valid(res_valid), .res_giant(res_giant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 180000);
      finish_run();
    end
  end

  // Sends len bytes; tpid1 at bytes 12..13, tpid2 at 16..17. With stall set,
  // a cycle with ready low and junk markers precedes every 97th byte.
  task automatic send_frame(input int len, input logic [15:0] tpid1,
                            input logic [15:0] tpid2, input bit stall,
                            input bit with_eof);
    for (int i = 0; i < len; i++) begin
      if (stall && (i % 97 == 5)) begin
        s_valid = 1'b1; s_ready = 1'b0; s_sof = 1'b1; s_eof = 1'b1;
        s_data = 8'h81;
        @(negedge clk);
      end
      s_valid = 1'b1; s_ready = 1'b1;
      s_sof = (i == 0);
      s_eof = with_eof && (i == len - 1);
      if (i == 12)      s_data = tpid1[15:8];
      else if (i == 13) s_data = tpid1[7:0];
      else if (i == 16) s_data = tpid2[15:8];
      else if (i == 17) s_data = tpid2[7:0];
      else              s_data = i[7:0];
      @(negedge clk);
    end
    s_valid = 1'b0; s_ready = 1'b1; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  // Sends a complete frame and checks the verdict and the one-cycle strobe.
  task automatic run_frame(input string req, input int len, input int ntags,
                           input logic [15:0] tpid1, input logic [15:0] tpid2,
                           input bit stall);
    int lim;
    bit exp;
    lim = (cfg_limit_en && cfg_limit >= 14'd1518) ? int'(cfg_limit) : 1518;
    lim = lim + 4 * ntags;
    exp = (len > lim);
    send_frame(len, tpid1, tpid2, stall, 1'b1);
    check(res_valid === 1'b1, {req, " result strobe"}, int'(res_valid), 1);
    check(res_giant === exp, {req, " giant verdict"}, int'(res_giant), int'(exp));
    @(negedge clk);
    check(res_valid === 1'b0, "R3 strobe one cycle", int'(res_valid), 0);
  endtask

  task automatic t_reset();
    check(res_valid === 1'b0, "R1 reset valid", int'(res_valid), 0);
    check(res_giant === 1'b0, "R1 reset giant", int'(res_giant), 0);
  endtask

  task automatic t_default_limit();
    cfg_limit_en = 1'b0; cfg_limit = 14'd3000;
    run_frame("R6 R4 default at limit", 1518, 0, 16'h0800, 16'h0000, 1'b0);
    run_frame("R6 R4 default above limit", 1519, 0, 16'h0800, 16'h0000, 1'b0);
  endtask

  task automatic t_programmed();
    cfg_limit_en = 1'b1; cfg_limit = 14'd2000;
    run_frame("R4 programmed at limit", 2000, 0, 16'h0800, 16'h0000, 1'b0);
    run_frame("R4 programmed above limit", 2001, 0, 16'h0800, 16'h0000, 1'b0);
    run_frame("R4 programmed below", 1600, 0, 16'h0800, 16'h0000, 1'b0);
  endtask

  task automatic t_floor();
    cfg_limit_en = 1'b1; cfg_limit = 14'd100;
    run_frame("R5 floor at 1518", 1518, 0, 16'h0800, 16'h0000, 1'b0);
    run_frame("R5 floor above", 1519, 0, 16'h0800, 16'h0000, 1'b0);
  endtask

  task automatic t_single_tag();
    cfg_limit_en = 1'b0;
    run_frame("R7 c-tag at limit", 1522, 1, 16'h8100, 16'h0800, 1'b0);
    run_frame("R7 c-tag above", 1523, 1, 16'h8100, 16'h0800, 1'b0);
    run_frame("R7 s-tag at limit", 1522, 1, 16'h88A8, 16'h0800, 1'b0);
    run_frame("R7 s-tag above", 1523, 1, 16'h88A8, 16'h0800, 1'b0);
  endtask

  task automatic t_double_tag();
    cfg_limit_en = 1'b1; cfg_limit = 14'd1600;
    run_frame("R8 double at limit", 1608, 2, 16'h88A8, 16'h8100, 1'b0);
    run_frame("R8 double above", 1609, 2, 16'h88A8, 16'h8100, 1'b0);
    run_frame("R8 inner without outer", 1601, 0, 16'h0800, 16'h8100, 1'b0);
  endtask

  task automatic t_stalls();
    cfg_limit_en = 1'b0;
    run_frame("R2 stalled at limit", 1518, 0, 16'h0800, 16'h0000, 1'b1);
    run_frame("R2 stalled above", 1519, 0, 16'h0800, 16'h0000, 1'b1);
  endtask

  task automatic t_restart();
    cfg_limit_en = 1'b0;
    send_frame(1000, 16'h8100, 16'h8100, 1'b0, 1'b0);
    check(res_valid === 1'b0, "R10 no strobe without eof", int'(res_valid), 0);
    run_frame("R10 restart at limit", 1518, 0, 16'h0800, 16'h0000, 1'b0);
  endtask

  task automatic t_saturate();
    cfg_limit_en = 1'b1; cfg_limit = 14'd16383;
    run_frame("R9 saturating count", 70000, 0, 16'h0800, 16'h0000, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_ready = 1'b1; s_sof = 1'b0; s_eof = 1'b0;
    s_data = '0; cfg_limit = '0; cfg_limit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_limit();
    t_programmed();
    t_floor();
    t_single_tag();
    t_double_tag();
    t_stalls();
    t_restart();
    t_saturate();
    finish_run();
  end
endmodule